// File: doc/BRIEF.md
# Baseline Correction and Zero Suppression Pipeline

This block cleans one channel's stream of 10-bit digitised samples before storage. Each accepted sample first has a fixed pedestal removed. The pedestal comes from a lookup memory addressed by the sample's position in the stream. The sample then passes a one-cycle slot reserved for a tail filter, which here forwards data unchanged. A recursive moving-average baseline estimate is then subtracted. Finally, a sample that stays below a programmable threshold produces no output.

Each sample that survives leaves with its stream position, so a downstream packer can rebuild the sparse record. The baseline estimate learns only from samples below the threshold, so pulses do not pull it upward. A register write port loads the pedestal memory, the threshold and the averaging window. A bypass input sends raw samples, with their positions, straight to the output.

Top module: `bzs_top`

## Requirements
- R1: A valid sample with `smp_start_i` high takes position 0. Each later valid sample takes the previous position plus one. Valid samples at position 1008 or beyond are dropped and produce no output, until the next start. `index_o` carries the position of each output sample.
- R2: A write with `reg_addr_i` below 1008 loads that pedestal entry. Address 1024 loads the threshold, all 10 bits. Address 1025 loads the window exponent from `reg_wdata_i[2:0]`, clamped into the range 2 to 5. Writes to any other address change nothing.
- R3: The pedestal stage outputs the sample minus the pedestal of its position, floored at zero.
- R4: The tail-filter slot forwards the sample value, position and flags unchanged, with one cycle of delay.
- R5: With window exponent k, the baseline is min(acc >> k, 1023). The corrected value is the pedestal-stage value minus the baseline, floored at zero. When the pedestal-stage value is below the threshold, acc becomes acc - (acc >> k) + value. Otherwise acc holds. A write to address 1025 clears acc to 0.
- R6: A corrected value below the threshold raises no `vld_o`. Any other value is output with exactly one `vld_o` pulse.
- R7: A sample taken while `bypass_i` is high is output unchanged, with its position and no threshold test. It leaves the baseline accumulator untouched.
- R8: A sample presented on a clock edge appears on `vld_o`, `data_o` and `index_o` after the third following edge.
- R9: After reset, `vld_o` is low, the position counter is 0, acc is 0, the threshold is 0 and the window exponent is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register/pedestal write strobe |
| reg_addr_i | input | 11 | Write address |
| reg_wdata_i | input | 10 | Write data |
| bypass_i | input | 1 | Raw pass-through mode |
| smp_vld_i | input | 1 | Input sample valid |
| smp_start_i | input | 1 | Marks the first sample of a stream |
| smp_i | input | 10 | Input sample |
| vld_o | output | 1 | Output sample valid |
| data_o | output | 10 | Corrected (or raw) sample |
| index_o | output | 10 | Position of the sample in its stream |

## Verification
Streams run with the threshold at zero and varied pedestals isolate the lookup subtraction, including samples that fall under their pedestal. A flat baseline with repeating pulses, under the narrowest window and the widest (clamped) window, separates a correct learning rule from one that also learns from pulses or mishandles the shift. A bypassed stream followed by a normal one shows that raw mode leaves the accumulator untouched. A stream longer than the lookup depth, then a new start, exposes the position limit and the restart.

// File: rtl/bzs_pkg.sv
package bzs_pkg;
  localparam int unsigned SMP_W   = 10;
  localparam int unsigned DEPTH   = 1008;
  localparam int unsigned IDX_W   = $clog2(DEPTH);
  localparam int unsigned ADDR_W  = 11;
  localparam int unsigned LOG_W   = 3;
  localparam int unsigned LOG_MIN = 2;
  localparam int unsigned LOG_MAX = 5;
  localparam int unsigned LOG_RST = 3;
  localparam int unsigned ACC_W   = SMP_W + LOG_MAX;

  localparam logic [IDX_W-1:0]  DEPTH_L  = IDX_W'(DEPTH);
  localparam logic [ADDR_W-1:0] THR_ADDR = ADDR_W'(1024);
  localparam logic [ADDR_W-1:0] WIN_ADDR = ADDR_W'(1025);
  localparam logic [SMP_W-1:0]  SMP_MAX  = '1;

  typedef struct packed {
    logic             vld;
    logic             byp;
    logic [IDX_W-1:0] idx;
    logic [SMP_W-1:0] dat;
  } beat_t;
endpackage

// File: rtl/bzs_ped_sub.sv
module bzs_ped_sub
  import bzs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ped_we_i,
  input  logic [IDX_W-1:0] ped_addr_i,
  input  logic [SMP_W-1:0] ped_data_i,
  input  logic             vld_i,
  input  logic             start_i,
  input  logic             byp_i,
  input  logic [SMP_W-1:0] smp_i,
  output beat_t            beat_o
);
  logic [SMP_W-1:0] ped_mem [DEPTH];
  logic [IDX_W-1:0] idx_q, cur_idx, rd_addr;
  logic             in_rng, accept;
  logic [SMP_W:0]   diff;
  logic [SMP_W-1:0] floor_v, ped_rd;
  beat_t            beat_q;

  always_ff @(posedge clk_i) begin
    if (ped_we_i) ped_mem[ped_addr_i] <= ped_data_i;
  end

  always_comb begin
    cur_idx = start_i ? '0 : idx_q;
    in_rng  = cur_idx < DEPTH_L;
    accept  = vld_i && in_rng;
    rd_addr = in_rng ? cur_idx : '0;
    ped_rd  = ped_mem[rd_addr];
    diff    = {1'b0, smp_i} - {1'b0, ped_rd};
    floor_v = diff[SMP_W] ? '0 : diff[SMP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      beat_q <= '0;
    end else begin
      if (vld_i) idx_q <= in_rng ? cur_idx + IDX_W'(1) : cur_idx;
      beat_q.vld <= accept;
      beat_q.byp <= byp_i;
      beat_q.idx <= cur_idx;
      beat_q.dat <= byp_i ? smp_i : floor_v;
    end
  end

  assign beat_o = beat_q;

  a_r3_floor_below_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !byp_i) |=> (beat_q.dat <= $past(smp_i)));
  a_r1_drop_past_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !start_i && idx_q >= DEPTH_L) |=> !beat_q.vld);
endmodule

// File: rtl/bzs_tail_pass.sv
module bzs_tail_pass
  import bzs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  beat_t beat_i,
  output beat_t beat_o
);
  beat_t beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= '0;
    else         beat_q <= beat_i;
  end

  assign beat_o = beat_q;

  a_r4_slot_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i.vld |=> (beat_o == $past(beat_i)));
endmodule

// File: rtl/bzs_mavg.sv
module bzs_mavg
  import bzs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  beat_t            beat_i,
  input  logic [SMP_W-1:0] thr_i,
  input  logic [LOG_W-1:0] wlog_i,
  input  logic             clr_i,
  output beat_t            beat_o
);
  logic [ACC_W-1:0] acc_q, shift;
  logic [SMP_W-1:0] base, x, y;
  logic             upd;
  beat_t            beat_q;

  always_comb begin
    x     = beat_i.dat;
    shift = acc_q >> wlog_i;
    base  = (shift > ACC_W'(SMP_MAX)) ? SMP_MAX : shift[SMP_W-1:0];
    y     = (x > base) ? x - base : '0;
    upd   = beat_i.vld && !beat_i.byp && (x < thr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      beat_q <= '0;
    end else begin
      if (clr_i)    acc_q <= '0;
      else if (upd) acc_q <= acc_q - shift + ACC_W'(x);
      beat_q.vld <= beat_i.vld;
      beat_q.byp <= beat_i.byp;
      beat_q.idx <= beat_i.idx;
      beat_q.dat <= beat_i.byp ? x : y;
    end
  end

  assign beat_o = beat_q;

  a_r5_acc_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q <= (ACC_W'(SMP_MAX) << wlog_i));
  a_r5_no_learn_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (!beat_i.vld || beat_i.byp || x >= thr_i)) |=> $stable(acc_q));
endmodule

// File: rtl/bzs_zsup.sv
module bzs_zsup
  import bzs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  beat_t            beat_i,
  input  logic [SMP_W-1:0] thr_i,
  output logic             vld_o,
  output logic [SMP_W-1:0] data_o,
  output logic [IDX_W-1:0] index_o
);
  logic keep;

  assign keep = beat_i.vld && (beat_i.byp || beat_i.dat >= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      data_o  <= '0;
      index_o <= '0;
    end else begin
      vld_o <= keep;
      if (keep) begin
        data_o  <= beat_i.dat;
        index_o <= beat_i.idx;
      end
    end
  end

  a_r6_suppress_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i.vld && !beat_i.byp && beat_i.dat < thr_i) |=> !vld_o);
  a_r7_bypass_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i.vld && beat_i.byp) |=> (vld_o && data_o == $past(beat_i.dat)));
  a_r1_index_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (index_o < DEPTH_L));
endmodule

// File: rtl/bzs_top.sv
module bzs_top
  import bzs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [SMP_W-1:0]  reg_wdata_i,
  input  logic              bypass_i,
  input  logic              smp_vld_i,
  input  logic              smp_start_i,
  input  logic [SMP_W-1:0]  smp_i,
  output logic              vld_o,
  output logic [SMP_W-1:0]  data_o,
  output logic [IDX_W-1:0]  index_o
);
  logic [SMP_W-1:0] thr_q;
  logic [LOG_W-1:0] wlog_q, wlog_in;
  logic             ped_we, thr_we, win_we;
  beat_t            s1, s2, s3;

  always_comb begin
    ped_we  = reg_we_i && (reg_addr_i < ADDR_W'(DEPTH));
    thr_we  = reg_we_i && (reg_addr_i == THR_ADDR);
    win_we  = reg_we_i && (reg_addr_i == WIN_ADDR);
    wlog_in = reg_wdata_i[LOG_W-1:0];
    if (wlog_in < LOG_W'(LOG_MIN))      wlog_in = LOG_W'(LOG_MIN);
    else if (wlog_in > LOG_W'(LOG_MAX)) wlog_in = LOG_W'(LOG_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '0;
      wlog_q <= LOG_W'(LOG_RST);
    end else begin
      if (thr_we) thr_q  <= reg_wdata_i;
      if (win_we) wlog_q <= wlog_in;
    end
  end

  bzs_ped_sub u_ped (
    .clk_i, .rst_ni,
    .ped_we_i   (ped_we),
    .ped_addr_i (reg_addr_i[IDX_W-1:0]),
    .ped_data_i (reg_wdata_i),
    .vld_i      (smp_vld_i),
    .start_i    (smp_start_i),
    .byp_i      (bypass_i),
    .smp_i      (smp_i),
    .beat_o     (s1)
  );

  bzs_tail_pass u_tail (.clk_i, .rst_ni, .beat_i(s1), .beat_o(s2));

  bzs_mavg u_mavg (
    .clk_i, .rst_ni,
    .beat_i (s2),
    .thr_i  (thr_q),
    .wlog_i (wlog_q),
    .clr_i  (win_we),
    .beat_o (s3)
  );

  bzs_zsup u_zs (
    .clk_i, .rst_ni,
    .beat_i  (s3),
    .thr_i   (thr_q),
    .vld_o   (vld_o),
    .data_o  (data_o),
    .index_o (index_o)
  );

  a_r2_window_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wlog_q >= LOG_W'(LOG_MIN)) && (wlog_q <= LOG_W'(LOG_MAX)));
  a_r8_no_early_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s3.vld) |=> !vld_o);
endmodule

// File: tb/bzs_top_tb.sv
`timescale 1ns/1ps
module bzs_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [10:0] reg_addr = '0;
  logic [9:0]  reg_wdata = '0;
  logic        bypass = 1'b0;
  logic        smp_vld = 1'b0;
  logic        smp_start = 1'b0;
  logic [9:0]  smp = '0;
  logic        vld_o;
  logic [9:0]  data_o;
  logic [9:0]  index_o;

  always #2 clk = ~clk;

  bzs_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .bypass_i(bypass), .smp_vld_i(smp_vld),
    .smp_start_i(smp_start), .smp_i(smp), .vld_o(vld_o), .data_o(data_o),
    .index_o(index_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  int m_ped [0:1007];
  int m_thr = 0, m_wlog = 3, m_acc = 0, m_idx = 0;
  int exp_d [0:2047];
  int exp_i [0:2047];
  int got_d [0:2047];
  int got_i [0:2047];
  int n_exp = 0, n_got = 0;

  always @(negedge clk) begin
    if (rst_n && vld_o && n_got < 2048) begin
      got_d[n_got] = int'(data_o);
      got_i[n_got] = int'(index_o);
      n_got++;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 11'(addr); reg_wdata = 10'(data);
    @(negedge clk);
    reg_we = 1'b0;
    if (addr < 1008) m_ped[addr] = data;
    else if (addr == 1024) m_thr = data;
    else if (addr == 1025) begin
      m_wlog = data % 8;
      if (m_wlog < 2) m_wlog = 2;
      if (m_wlog > 5) m_wlog = 5;
      m_acc = 0;
    end
  endtask

  // drives one sample for one cycle starting at the current negedge
  task automatic send(int s, bit st);
    int cur, x, base, y;
    bit keep;
    smp_vld = 1'b1; smp_start = st; smp = 10'(s);
    cur = st ? 0 : m_idx;
    if (cur < 1008) begin
      if (bypass) begin
        y = s; keep = 1;
      end else begin
        x = (s > m_ped[cur]) ? s - m_ped[cur] : 0;
        base = m_acc >> m_wlog;
        if (base > 1023) base = 1023;
        y = (x > base) ? x - base : 0;
        if (x < m_thr) m_acc = m_acc - (m_acc >> m_wlog) + x;
        keep = (y >= m_thr);
      end
      if (keep) begin
        exp_d[n_exp] = y; exp_i[n_exp] = cur; n_exp++;
      end
      m_idx = cur + 1;
    end else m_idx = cur;
    @(negedge clk);
    smp_vld = 1'b0; smp_start = 1'b0;
  endtask

  task automatic begin_stream();
    @(negedge clk);
    n_exp = 0; n_got = 0;
  endtask

  task automatic end_stream(string req);
    int errs;
    repeat (8) @(negedge clk);
    check({req, " output count"}, n_got, n_exp);
    errs = 0;
    for (int k = 0; k < n_exp && k < n_got; k++) begin
      if (got_d[k] != exp_d[k] || got_i[k] != exp_i[k]) begin
        errs++;
        if (errs <= 4)
          $display("FAIL %s: item %0d actual data %0d idx %0d expected data %0d idx %0d",
                   req, k, got_d[k], got_i[k], exp_d[k], exp_i[k]);
      end
    end
    n_chk++;
    if (errs != 0) n_fail++;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 vld_o low after reset", int'(vld_o), 0);
    // no start: position counter must already be 0; threshold 0 keeps all
    begin_stream();
    for (int k = 0; k < 5; k++) send(100 + k, 1'b0);
    end_stream("R9 reset position and threshold");
    check("R9 first index", got_i[0], 0);
  endtask

  task automatic t_pedestal();
    for (int k = 0; k < 64; k++) wr(k, (k * 37) % 200);
    begin_stream();
    for (int k = 0; k < 64; k++) send((k * 53) % 300, k == 0);
    end_stream("R3 pedestal subtraction with floor");
    wr(1015, 999);   // R2: unmapped address, must not touch anything
    wr(1030, 500);
    begin_stream();
    for (int k = 0; k < 10; k++) send(5 + k, k == 0);
    end_stream("R2 unmapped writes ignored");
  endtask

  task automatic t_latency();
    int cyc;
    begin_stream();
    send(700, 1'b1);
    // send consumed one negedge after the driving negedge
    cyc = 1;
    while (!vld_o && cyc < 10) begin
      @(negedge clk); cyc++;
    end
    check("R8 latency in edges", cyc, 4);
    check("R4 value through tail slot", int'(data_o), exp_d[0]);
    end_stream("R8 single sample");
  endtask

  task automatic t_baseline(int win, string req);
    int v;
    wr(1024, 120);
    wr(1025, win);
    begin_stream();
    for (int k = 0; k < 200; k++) begin
      v = ((k % 40) >= 20 && (k % 40) < 24) ? 400 + k : 60 + (k % 7);
      send(v + ((k < 64) ? (k * 37) % 200 : 0), k == 0);
    end
    end_stream(req);
    check({req, " R6 some suppressed"}, int'(n_got < 200), 1);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    bypass = 1'b1;
    wr(1024, 500);
    begin_stream();
    for (int k = 0; k < 30; k++) send((k * 91) % 1024, k == 0);
    end_stream("R7 bypass raw samples");
    @(negedge clk);
    bypass = 1'b0;
    wr(1024, 120);
    begin_stream();
    for (int k = 0; k < 40; k++) send(80 + ((k < 64) ? (k * 37) % 200 : 0) + (k % 5), k == 0);
    end_stream("R7 baseline untouched by bypass");
  endtask

  task automatic t_overflow();
    @(negedge clk);
    bypass = 1'b1;
    begin_stream();
    for (int k = 0; k < 1012; k++) send(k % 1024, k == 0);
    end_stream("R1 depth limit");
    check("R1 last index", got_i[n_got > 0 ? n_got - 1 : 0], 1007);
    begin_stream();
    send(33, 1'b0);
    send(44, 1'b1);
    send(55, 1'b0);
    end_stream("R1 restart after limit");
    check("R1 restart index", got_i[0], 0);
    @(negedge clk);
    bypass = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 1008; k++) m_ped[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 1008; k++) wr(k, 0);
    t_reset();
    t_pedestal();
    t_latency();
    t_baseline(2, "R5 window exponent 2");
    t_baseline(7, "R5 R2 window clamp to 5");
    t_baseline(0, "R5 R2 window clamp to 2");
    t_bypass();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule